// File: doc/BRIEF.md
# Trap-Level Privileged State Register Bank

This block holds the privileged control and status state of one processor core. Software reaches it through a register-number address with separate read and write strobes. Writes take effect on the clock edge that samples the strobe. A read returns its data one cycle later, marked by a valid pulse. The bank holds:

- a processor-state word and a hyper-state word;
- a 3-bit trap level (TL);
- two trap base addresses;
- five register sets (trap PC, trap next-PC, trap state, trap type, hyper trap state) with one slot per trap level;
- a soft-interrupt register with write-only set and clear aliases;
- eight scratch registers and eight interrupt-queue head/tail pointers;
- the timer, FP status, load/store control, partition and context registers.

Several writes are masked or transformed as they are stored. The per-trap-level registers are always addressed through slot TL−1. A read-only register packs the state that address translation needs into one 64-bit word. Each write to TL re-evaluates a trap-level-zero interrupt request, which stays registered until the next TL write. The error output pulses together with the read timing for any access that is not allowed: an unknown register, a read of a write-only alias, a write to the read-only word, or a per-trap-level access while TL is 0. A refused access changes no state.

Top module: `priv_state_bank`

## Requirements
- R1: A read strobe sampled at a clock edge drives `rvalid` high and `rdata` with the register value after that edge. `rvalid` is low in every cycle that follows an edge with no read strobe.
- R2: After reset, the timer register (address 6) reads 0x8000_0000_0000_0000, the hyper-state register (address 4) reads 0x800, the strand status register (address 5) reads 0x50000, and the processor-state word (address 0) and TL (address 1) read 0.
- R3: A write to the processor-state word (address 0) keeps only mask 0xBDE. The kept bits are: 1 interrupt enable, 2 privileged, 3 address mask, 4 FP enable, 7:6 memory model, 8 trap little-endian, 9 current little-endian, 11 partition bit. All other bits read back as 0.
- R4: A write to the trap base address (address 2) stores the written value AND NOT 0x7FFF. The hyper trap base (address 3) stores the full value.
- R5: TL (address 1) stores a written value, saturated at parameter MAXTL. Trap PC (16), trap next-PC (17), trap state (18), trap type (19) and hyper trap state (20) each access slot TL−1, so a value written at one TL is read back only at the same TL.
- R6: While TL is 0, any read or write of addresses 16 to 20 raises `err`, reads 0, and changes no slot.
- R7: Address 12 reads the packed context word. Its bits are: bit 0 hyper-privileged (hyper-state bit 2), bit 1 red state (hyper-state bit 5), bit 2 privileged, bit 3 address mask, bits 5:4 load/store control (address 8) bits 3:2, bits 15:8 partition id (address 9), bits 18:16 TL, bits 47:32 primary context (address 10), bits 63:48 secondary context (address 11), and 0 elsewhere. A write to address 12 raises `err` and changes nothing.
- R8: On each TL write, `tlz_irq` becomes 1 if hyper-state bit 0 is set, the new TL is 0 and hyper-state bit 2 is clear; otherwise it becomes 0. No other access changes `tlz_irq`.
- R9: A read of the FP status register (address 7) always returns bits 1:0 as 1. The other bits read as last written.
- R10: A write to address 14 ORs the data into the soft-interrupt register (address 13). A write to address 15 clears the bits set in the data. A read of address 14 or 15 raises `err` and returns 0.
- R11: An access to an unassigned address (for example 63) raises `err`, returns 0 on a read and changes no register.
- R12: When read and write strobes fall in the same cycle, the write is stored and the read returns the value held before that write.
- R13: Scratch registers (addresses 24 to 31) and queue pointers (addresses 32 to 39) each store a full 64-bit value independently.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| addr | input | 6 | Register number |
| wdata | input | 64 | Write data |
| rdata | output | 64 | Read data, valid with rvalid |
| rvalid | output | 1 | Read data valid, one cycle after rd_en |
| err | output | 1 | Refused access, one cycle after the strobe |
| tlz_irq | output | 1 | Trap-level-zero interrupt request |

## Verification
A read and a write can be applied to the same register in one cycle. The bench provokes this by raising both strobes on a scratch register that already holds a known value. The returned data must equal the old value, and a later read must return the new one. A second overlap is a TL write that re-evaluates `tlz_irq` while other writes leave it alone. The bench checks the request after each TL write and after an unrelated write in between.

// File: rtl/priv_state_bank.sv
module priv_state_bank #(
  parameter int MAXTL = 6,
  parameter int NSCR  = 8,
  parameter int NQ    = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [5:0]  addr,
  input  logic [63:0] wdata,
  output logic [63:0] rdata,
  output logic        rvalid,
  output logic        err,
  output logic        tlz_irq
);
  localparam logic [63:0] PST_MASK = 64'hBDE;
  localparam logic [63:0] TBA_MASK = ~64'h7FFF;
  localparam logic [5:0] A_PST = 6'd0, A_TL = 6'd1, A_TBA = 6'd2, A_HTBA = 6'd3,
    A_HST = 6'd4, A_STS = 6'd5, A_TICK = 6'd6, A_FPS = 6'd7, A_LSU = 6'd8,
    A_PID = 6'd9, A_PCTX = 6'd10, A_SCTX = 6'd11, A_CTX = 6'd12, A_SINT = 6'd13,
    A_SSET = 6'd14, A_SCLR = 6'd15, A_TPC = 6'd16, A_TNPC = 6'd17, A_TST = 6'd18,
    A_TTY = 6'd19, A_HTST = 6'd20, A_SCR = 6'd24, A_Q = 6'd32;

  logic [63:0] pst, tba, htba, hst, sts, tick, fps, lsu, pid, pctx, sctx, sint;
  logic [2:0]  tl;
  logic [63:0] tpc [MAXTL], tnpc [MAXTL], tst [MAXTL], tty [MAXTL], htst [MAXTL];
  logic [63:0] scr [NSCR], qp [NQ];

  logic [2:0]  sidx, tl_new;
  logic        scr_hit, q_hit, slot_hit, rd_ok, wr_ok;
  logic [63:0] rd_val, ctx;

  assign sidx     = tl - 3'd1;
  assign tl_new   = (wdata > 64'(MAXTL)) ? 3'(MAXTL) : wdata[2:0];
  assign scr_hit  = addr >= A_SCR && addr < A_SCR + 6'(NSCR);
  assign q_hit    = addr >= A_Q && addr < A_Q + 6'(NQ);
  assign slot_hit = addr >= A_TPC && addr <= A_HTST;
  assign ctx = {sctx[15:0], pctx[15:0], 13'd0, tl, pid[7:0], 2'd0, lsu[3:2],
                pst[3], pst[2], hst[5], hst[2]};

  always_comb begin
    rd_val = '0;
    rd_ok  = 1'b1;
    wr_ok  = 1'b1;
    if (scr_hit)      rd_val = scr[addr[2:0]];
    else if (q_hit)   rd_val = qp[addr[2:0]];
    else if (slot_hit) begin
      rd_ok = tl != 3'd0;
      wr_ok = rd_ok;
      if (rd_ok)
        case (addr)
          A_TPC:   rd_val = tpc[sidx];
          A_TNPC:  rd_val = tnpc[sidx];
          A_TST:   rd_val = tst[sidx];
          A_TTY:   rd_val = tty[sidx];
          default: rd_val = htst[sidx];
        endcase
    end else
      case (addr)
        A_PST:  rd_val = pst;
        A_TL:   rd_val = {61'd0, tl};
        A_TBA:  rd_val = tba;
        A_HTBA: rd_val = htba;
        A_HST:  rd_val = hst;
        A_STS:  rd_val = sts;
        A_TICK: rd_val = tick;
        A_FPS:  rd_val = fps | 64'h3;
        A_LSU:  rd_val = lsu;
        A_PID:  rd_val = pid;
        A_PCTX: rd_val = pctx;
        A_SCTX: rd_val = sctx;
        A_CTX:  begin rd_val = ctx; wr_ok = 1'b0; end
        A_SINT: rd_val = sint;
        A_SSET, A_SCLR: rd_ok = 1'b0;
        default: begin rd_ok = 1'b0; wr_ok = 1'b0; end
      endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pst <= '0; tl <= '0; tba <= '0; htba <= '0; hst <= 64'h800; sts <= 64'h50000;
      tick <= 64'h8000_0000_0000_0000; fps <= '0; lsu <= '0; pid <= '0;
      pctx <= '0; sctx <= '0; sint <= '0;
      for (int i = 0; i < MAXTL; i++) begin
        tpc[i] <= '0; tnpc[i] <= '0; tst[i] <= '0; tty[i] <= '0; htst[i] <= '0;
      end
      for (int i = 0; i < NSCR; i++) scr[i] <= '0;
      for (int i = 0; i < NQ; i++) qp[i] <= '0;
      rdata <= '0; rvalid <= 1'b0; err <= 1'b0; tlz_irq <= 1'b0;
    end else begin
      rvalid <= rd_en;
      err    <= (rd_en && !rd_ok) || (wr_en && !wr_ok);
      if (rd_en) rdata <= rd_ok ? rd_val : '0;
      if (wr_en && wr_ok) begin
        if (scr_hit)    scr[addr[2:0]] <= wdata;
        else if (q_hit) qp[addr[2:0]]  <= wdata;
        else
          case (addr)
            A_PST:  pst  <= wdata & PST_MASK;
            A_TL: begin
              tl      <= tl_new;
              tlz_irq <= hst[0] && tl_new == 3'd0 && !hst[2];
            end
            A_TBA:  tba  <= wdata & TBA_MASK;
            A_HTBA: htba <= wdata;
            A_HST:  hst  <= wdata;
            A_STS:  sts  <= wdata;
            A_TICK: tick <= wdata;
            A_FPS:  fps  <= wdata;
            A_LSU:  lsu  <= wdata;
            A_PID:  pid  <= wdata;
            A_PCTX: pctx <= wdata;
            A_SCTX: sctx <= wdata;
            A_SINT: sint <= wdata;
            A_SSET: sint <= sint | wdata;
            A_SCLR: sint <= sint & ~wdata;
            A_TPC:  tpc[sidx]  <= wdata;
            A_TNPC: tnpc[sidx] <= wdata;
            A_TST:  tst[sidx]  <= wdata;
            A_TTY:  tty[sidx]  <= wdata;
            A_HTST: htst[sidx] <= wdata;
            default: ;
          endcase
      end
    end
  end
endmodule

// File: rtl/priv_state_bank_chk.sv
module priv_state_bank_chk #(
  parameter int MAXTL = 6
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rd_en,
  input logic        wr_en,
  input logic [5:0]  addr,
  input logic [63:0] wdata,
  input logic [63:0] rdata,
  input logic        rvalid,
  input logic        err,
  input logic        tlz_irq
);
  p_rvalid_r1: assert property (@(posedge clk) disable iff (!rst_n) rd_en |=> rvalid);
  p_no_rvalid_r1: assert property (@(posedge clk) disable iff (!rst_n) !rd_en |=> !rvalid);
  p_pst_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && $past(addr) == 6'd0 |-> (rdata & ~64'hBDE) == 64'd0);
  p_tba_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && $past(addr) == 6'd2 |-> rdata[14:0] == 15'd0);
  p_tl_sat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && $past(addr) == 6'd1 |-> rdata <= 64'(MAXTL));
  p_tlz_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == 6'd1) |=> $stable(tlz_irq));
  p_fps_dirty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && !err && $past(addr) == 6'd7 |-> rdata[1:0] == 2'b11);
  p_alias_rd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && (addr == 6'd14 || addr == 6'd15) |=> err);
  p_err_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid && err && !$past(wr_en) |-> rdata == 64'd0);
  p_unknown_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en || wr_en) && addr >= 6'd40 |=> err);
endmodule

bind priv_state_bank priv_state_bank_chk #(.MAXTL(MAXTL)) u_chk (.*);

// File: tb/priv_state_bank_test.sv
`timescale 1ns/1ps
module priv_state_bank_test;
  logic clk = 1'b0, rst_n = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [5:0] addr = '0;
  logic [63:0] wdata = '0, rdata;
  logic rvalid, err, tlz_irq;
  int nchk = 0, nfail = 0;
  bit done = 0;

  priv_state_bank #(.MAXTL(6)) uut (.clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid), .err(err), .tlz_irq(tlz_irq));

  always #2.5 clk = ~clk;

  localparam int NV = 13;
  localparam logic [5:0] VA [NV] = '{6'd0, 6'd2, 6'd3, 6'd7, 6'd8, 6'd9, 6'd10, 6'd11,
                                     6'd24, 6'd31, 6'd32, 6'd39, 6'd13};
  localparam logic [63:0] VW [NV] = '{64'hFFFF_FFFF_FFFF_FFFF, 64'h1234_5678_9ABC_DEFF,
    64'h0000_0000_0000_FFFF, 64'h4, 64'hC, 64'h3F, 64'h1111, 64'h2222,
    64'hA5A5_A5A5_A5A5_A5A5, 64'h5A5A_0000_1234_FFFF, 64'h0123_4567_89AB_CDEF,
    64'hFEDC_BA98_7654_3210, 64'hF0};
  localparam logic [63:0] VE [NV] = '{64'hBDE, 64'h1234_5678_9ABC_8000,
    64'h0000_0000_0000_FFFF, 64'h7, 64'hC, 64'h3F, 64'h1111, 64'h2222,
    64'hA5A5_A5A5_A5A5_A5A5, 64'h5A5A_0000_1234_FFFF, 64'h0123_4567_89AB_CDEF,
    64'hFEDC_BA98_7654_3210, 64'hF0};

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [63:0] d, output logic e);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0; e = err;
  endtask

  task automatic rd(input logic [5:0] a, output logic [63:0] d, output logic e);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; d = rdata; e = err;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic e;
    repeat (4) @(negedge clk);
    check("R1 rvalid at reset", {63'd0, rvalid}, 64'd0);
    rst_n = 1'b1;
    rd(6'd6, d, e); check("R2 tick reset", d, 64'h8000_0000_0000_0000);
    check("R1 rvalid after read", {63'd0, rvalid}, 64'd1);
    @(negedge clk); check("R1 rvalid idle", {63'd0, rvalid}, 64'd0);
    rd(6'd4, d, e); check("R2 hyper-state reset", d, 64'h800);
    rd(6'd5, d, e); check("R2 strand status reset", d, 64'h50000);
    rd(6'd0, d, e); check("R2 state word reset", d, 64'd0);
    rd(6'd1, d, e); check("R2 TL reset", d, 64'd0);

    for (int i = 0; i < NV; i++) begin
      wr(VA[i], VW[i], e);
      rd(VA[i], d, e);
      check($sformatf("R3/R4/R9/R13 vector %0d addr %0d", i, VA[i]), d, VE[i]);
    end

    rd(6'd12, d, e); check("R7 context word", d, 64'h2222_1111_0000_3F3C);
    wr(6'd12, 64'hFFFF, e); check("R7 context write err", {63'd0, e}, 64'd1);
    rd(6'd12, d, e); check("R7 context unchanged", d, 64'h2222_1111_0000_3F3C);

    wr(6'd16, 64'hDEAD, e); check("R6 slot write at TL0 err", {63'd0, e}, 64'd1);
    rd(6'd16, d, e); check("R6 slot read at TL0 err", {63'd0, e}, 64'd1);
    check("R6 slot read at TL0 data", d, 64'd0);
    wr(6'd1, 64'd1, e);
    rd(6'd16, d, e); check("R6 slot untouched", d, 64'd0);
    wr(6'd16, 64'h100, e); wr(6'd19, 64'h11, e);
    wr(6'd1, 64'd2, e);
    wr(6'd16, 64'h200, e); wr(6'd19, 64'h22, e);
    rd(6'd16, d, e); check("R5 trap PC at TL2", d, 64'h200);
    wr(6'd1, 64'd1, e);
    rd(6'd16, d, e); check("R5 trap PC at TL1", d, 64'h100);
    rd(6'd19, d, e); check("R5 trap type at TL1", d, 64'h11);
    wr(6'd1, 64'd7, e);
    rd(6'd1, d, e); check("R5 TL saturates", d, 64'd6);
    rd(6'd12, d, e); check("R7 TL field", d, 64'h2222_1111_0006_3F3C);

    wr(6'd4, 64'h801, e);
    wr(6'd1, 64'd0, e); check("R8 request raised", {63'd0, tlz_irq}, 64'd1);
    wr(6'd25, 64'h77, e); check("R8 request held", {63'd0, tlz_irq}, 64'd1);
    wr(6'd1, 64'd1, e); check("R8 request dropped TL1", {63'd0, tlz_irq}, 64'd0);
    wr(6'd4, 64'h805, e);
    wr(6'd1, 64'd0, e); check("R8 hyper-privileged blocks", {63'd0, tlz_irq}, 64'd0);

    wr(6'd14, 64'h0F, e);
    rd(6'd13, d, e); check("R10 set alias", d, 64'hFF);
    wr(6'd15, 64'h3C, e);
    rd(6'd13, d, e); check("R10 clear alias", d, 64'hC3);
    rd(6'd14, d, e); check("R10 set alias read err", {63'd0, e}, 64'd1);
    rd(6'd15, d, e); check("R10 clear alias read err", {63'd0, e}, 64'd1);

    rd(6'd63, d, e); check("R11 unknown read err", {63'd0, e}, 64'd1);
    check("R11 unknown read data", d, 64'd0);
    wr(6'd63, 64'h1, e); check("R11 unknown write err", {63'd0, e}, 64'd1);

    @(negedge clk); rd_en = 1'b1; wr_en = 1'b1; addr = 6'd25; wdata = 64'h99;
    @(negedge clk); rd_en = 1'b0; wr_en = 1'b0;
    check("R12 overlapped read old value", rdata, 64'h77);
    rd(6'd25, d, e); check("R12 write stored", d, 64'h99);
    rd(6'd24, d, e); check("R13 neighbour scratch intact", d, 64'hA5A5_A5A5_A5A5_A5A5);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule